// File: doc/BRIEF.md
# Two-Register Vector Merge Unit

This block merges two vectors of unsigned keys. Each vector holds LANES keys that are already in ascending order, with lane 0 holding the smallest. The result is the 2·LANES keys in ascending order, split over two output vectors: the low vector holds the smallest LANES keys and the high vector holds the largest LANES keys. Each key can carry an index that moves with it. The index names the record the key belongs to.

The unit holds two working vectors, called the lower and the upper register. A start strobe while idle loads input A into the lower register and input B into the upper register. After that, one step runs on every clock. A step forms the lane-wise minimum and the lane-wise maximum of the two registers. The maximum goes into the upper register. The minimum is rotated down by one lane, so lane i takes lane i+1 and the top lane takes lane 0, and the rotated vector goes into the lower register. Both results are computed from the register values as they stood before the step. After exactly LANES steps the registers hold the merged result. The unit then drops busy and pulses done for one cycle. The outputs keep their values until the next accepted start.

Top module: `vmerge_unit`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are 0 and all four output vectors are zero.
- R2: A start seen on a clock edge while busy is 0 loads A into the lower register and B into the upper register, and busy reads 1 after that edge.
- R3: Done is high for exactly one cycle, right after the LANES-th clock edge that follows the load edge. Busy falls on that same edge, so busy and done are never high together.
- R4: When done is high, the low vector holds the LANES smallest keys and the high vector holds the LANES largest keys, both in ascending order from lane 0 upward. For ordering, every lane is compared as an unsigned number.
- R5: Every input index appears exactly once across the two output index vectors, and it sits in the same lane as the key it entered with. This holds for any pattern of duplicate keys.
- R6: Two keys are exchanged between the registers only when the lower one is strictly greater than the upper one. A tie keeps both pairs where they are. As a result, if every key is equal, the outputs return A's key/index pairs in their original lanes on the low side and B's on the high side.
- R7: A start strobe while busy is 1 is ignored. The run in progress ends at its original time with the result of the original inputs.
- R8: From the done cycle until the next accepted start, the output vectors do not change, whatever the data inputs do.
- R9: A start in the cycle where done is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a merge of A and B when idle |
| a_key | input | LANES*KEY_W | Sorted keys of vector A, lane 0 in the low bits |
| a_idx | input | LANES*IDX_W | Indices that travel with the A keys |
| b_key | input | LANES*KEY_W | Sorted keys of vector B, lane 0 in the low bits |
| b_idx | input | LANES*IDX_W | Indices that travel with the B keys |
| busy | output | 1 | A merge is running |
| done | output | 1 | One-cycle pulse when the result is ready |
| lo_key | output | LANES*KEY_W | Smallest LANES keys, ascending |
| lo_idx | output | LANES*IDX_W | Indices of the low keys (zero if the index is not carried) |
| hi_key | output | LANES*KEY_W | Largest LANES keys, ascending |
| hi_idx | output | LANES*IDX_W | Indices of the high keys (zero if the index is not carried) |

## Verification
The step count and the register contents are the only internal state, and each one shows at the ports soon after it goes wrong. A miscounted step moves the done pulse away from the LANES-th edge after the load. The cycle-by-cycle busy/done comparison flags that in the first cycle where the two disagree. A bad swap, a rotation in the wrong direction, or a min/max that reads a value already updated in the same step leaves the keys out of order, or drops or duplicates an index. That shows in the outputs in the done cycle of the same run. Running with all keys equal exposes a comparison that swaps on ties, because the original lane placement is then lost.

// File: rtl/vmerge_pkg.sv
package vmerge_pkg;

    // Run phase of the merge unit
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } vm_phase_e;

endpackage

// File: rtl/vmerge_cmpx.sv
// One lane of the min/max stage: the key/index pair with the smaller key goes
// to the min side. An exchange happens only on a strict greater-than, so ties
// stay where they are.
module vmerge_cmpx #(
    parameter int KEY_W = 32,
    parameter int IDX_W = 32
) (
    input  logic [KEY_W-1:0] lo_k,
    input  logic [IDX_W-1:0] lo_i,
    input  logic [KEY_W-1:0] up_k,
    input  logic [IDX_W-1:0] up_i,
    output logic [KEY_W-1:0] min_k,
    output logic [IDX_W-1:0] min_i,
    output logic [KEY_W-1:0] max_k,
    output logic [IDX_W-1:0] max_i
);
    logic swap;

    always_comb begin
        swap  = (lo_k > up_k);
        min_k = swap ? up_k : lo_k;
        min_i = swap ? up_i : lo_i;
        max_k = swap ? lo_k : up_k;
        max_i = swap ? lo_i : up_i;
    end
endmodule

// File: rtl/vmerge_rot.sv
// Rotates a vector down by one element: lane i takes lane i+1 and the top
// lane takes lane 0. This is the vector joined to itself, shifted right by one
// element.
module vmerge_rot #(
    parameter int LANES = 8,
    parameter int W     = 32
) (
    input  logic [LANES*W-1:0] din,
    output logic [LANES*W-1:0] dout
);
    always_comb begin
        dout = {din[W-1:0], din[LANES*W-1:W]};
    end
endmodule

// File: rtl/vmerge_unit.sv
module vmerge_unit #(
    parameter int LANES     = 8,
    parameter int KEY_W     = 32,
    parameter int IDX_W     = 32,
    parameter bit CARRY_IDX = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LANES*KEY_W-1:0] a_key,
    input  logic [LANES*IDX_W-1:0] a_idx,
    input  logic [LANES*KEY_W-1:0] b_key,
    input  logic [LANES*IDX_W-1:0] b_idx,
    output logic                   busy,
    output logic                   done,
    output logic [LANES*KEY_W-1:0] lo_key,
    output logic [LANES*IDX_W-1:0] lo_idx,
    output logic [LANES*KEY_W-1:0] hi_key,
    output logic [LANES*IDX_W-1:0] hi_idx
);
    import vmerge_pkg::*;

    localparam int VK = LANES * KEY_W;
    localparam int VI = LANES * IDX_W;
    localparam int CW = $clog2(LANES + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(LANES - 1);

    typedef struct packed {
        vm_phase_e         phase;
        logic              done;
        logic [CW-1:0]     steps;
        logic [VK-1:0]     dn_k;
        logic [VI-1:0]     dn_i;
        logic [VK-1:0]     up_k;
        logic [VI-1:0]     up_i;
    } vm_state_t;

    vm_state_t st_q, st_d;

    // Indices held at zero when the payload is not carried
    logic [VI-1:0] a_idx_g, b_idx_g;
    generate
        if (CARRY_IDX) begin : g_idx_on
            assign a_idx_g = a_idx;
            assign b_idx_g = b_idx;
        end else begin : g_idx_off
            assign a_idx_g = '0;
            assign b_idx_g = '0;
        end
    endgenerate

    // Lane-wise min/max, computed from the registered values only
    logic [VK-1:0] min_k_d, max_k_d, rot_k_d;
    logic [VI-1:0] min_i_d, max_i_d, rot_i_d;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vmerge_cmpx #(
            .KEY_W (KEY_W),
            .IDX_W (IDX_W)
        ) u_cmpx (
            .lo_k  (st_q.dn_k[l*KEY_W +: KEY_W]),
            .lo_i  (st_q.dn_i[l*IDX_W +: IDX_W]),
            .up_k  (st_q.up_k[l*KEY_W +: KEY_W]),
            .up_i  (st_q.up_i[l*IDX_W +: IDX_W]),
            .min_k (min_k_d[l*KEY_W +: KEY_W]),
            .min_i (min_i_d[l*IDX_W +: IDX_W]),
            .max_k (max_k_d[l*KEY_W +: KEY_W]),
            .max_i (max_i_d[l*IDX_W +: IDX_W])
        );
    end

    // Rotate the min vector; keys and indices get the same lane permutation
    vmerge_rot #(.LANES(LANES), .W(KEY_W)) u_rot_k (.din(min_k_d), .dout(rot_k_d));
    vmerge_rot #(.LANES(LANES), .W(IDX_W)) u_rot_i (.din(min_i_d), .dout(rot_i_d));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start) begin
                st_d.phase = PH_RUN;
                st_d.steps = '0;
                st_d.dn_k  = a_key;
                st_d.dn_i  = a_idx_g;
                st_d.up_k  = b_key;
                st_d.up_i  = b_idx_g;
            end
        end else begin
            st_d.dn_k  = rot_k_d;
            st_d.dn_i  = rot_i_d;
            st_d.up_k  = max_k_d;
            st_d.up_i  = max_i_d;
            st_d.steps = st_q.steps + 1'b1;
            if (st_q.steps == LAST_STEP) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.phase == PH_RUN);
    assign done   = st_q.done;
    assign lo_key = st_q.dn_k;
    assign lo_idx = st_q.dn_i;
    assign hi_key = st_q.up_k;
    assign hi_idx = st_q.up_i;

endmodule

// File: rtl/vmerge_unit_chk.sv
module vmerge_unit_chk #(
    parameter int LANES = 8,
    parameter int KEY_W = 32,
    parameter int IDX_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic [LANES*KEY_W-1:0] lo_key,
    input logic [LANES*IDX_W-1:0] lo_idx,
    input logic [LANES*KEY_W-1:0] hi_key,
    input logic [LANES*IDX_W-1:0] hi_idx
);
    localparam int CW = $clog2(LANES + 2);

    // Cycles since the last accepted start, counted while busy
    logic [CW-1:0] run_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
        end else if (busy && (run_cnt != CW'(LANES + 1))) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    logic [2*LANES*KEY_W-1:0] all_key;
    assign all_key = {hi_key, lo_key};

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (!busy && !done));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3, R7 (a start while busy must not restart the run)
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CW'(LANES)));

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(lo_key) && $stable(hi_key)
                               && $stable(lo_idx) && $stable(hi_idx)));

    for (genvar p = 0; p < 2*LANES-1; p++) begin : g_ord
        // R4
        sorted_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (all_key[p*KEY_W +: KEY_W] <= all_key[(p+1)*KEY_W +: KEY_W]));
    end
endmodule

bind vmerge_unit vmerge_unit_chk #(
    .LANES (LANES),
    .KEY_W (KEY_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .lo_key (lo_key),
    .lo_idx (lo_idx),
    .hi_key (hi_key),
    .hi_idx (hi_idx)
);

// File: tb/vmerge_unit_tb.sv
module vmerge_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int KEY_W = 32;
    localparam int IDX_W = 32;
    localparam int IBASE = 256;

    typedef int unsigned vec_t [LANES];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LANES*KEY_W-1:0] a_key = '0, b_key = '0;
    logic [LANES*IDX_W-1:0] a_idx = '0, b_idx = '0;
    logic busy, done;
    logic [LANES*KEY_W-1:0] lo_key, hi_key;
    logic [LANES*IDX_W-1:0] lo_idx, hi_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmerge_unit #(.LANES(LANES), .KEY_W(KEY_W), .IDX_W(IDX_W), .CARRY_IDX(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_key(a_key), .a_idx(a_idx), .b_key(b_key), .b_idx(b_idx),
        .busy(busy), .done(done),
        .lo_key(lo_key), .lo_idx(lo_idx), .hi_key(hi_key), .hi_idx(hi_idx)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Behavioural reference for the control timing
    bit mbusy = 0, mdone = 0;
    int mcnt = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mbusy = 0; mdone = 0; mcnt = 0;
        end else begin
            mdone = 0;
            if (mbusy) begin
                mcnt++;
                if (mcnt == LANES) begin mbusy = 0; mdone = 1; end
            end else if (start) begin
                mbusy = 1; mcnt = 0;
            end
        end
    end

    // Expected result of the run accepted last
    int unsigned orig_key [2*LANES];
    int unsigned exp_sorted [2*LANES];
    bit tie_mode = 0;
    bit result_seen = 0;

    task automatic fail(input string req, input string what, input longint act, input longint exp);
        errors++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic check_result();
        bit seen [2*LANES];
        result_seen = 1;
        foreach (seen[j]) seen[j] = 0;
        for (int l = 0; l < LANES; l++) begin
            checks++;
            if (lo_key[l*KEY_W +: KEY_W] !== exp_sorted[l])
                fail("R4", $sformatf("low lane %0d", l), lo_key[l*KEY_W +: KEY_W], exp_sorted[l]);
            checks++;
            if (hi_key[l*KEY_W +: KEY_W] !== exp_sorted[LANES+l])
                fail("R4", $sformatf("high lane %0d", l), hi_key[l*KEY_W +: KEY_W], exp_sorted[LANES+l]);
        end
        for (int p = 0; p < 2*LANES; p++) begin
            int unsigned k, ix;
            k  = (p < LANES) ? lo_key[p*KEY_W +: KEY_W] : hi_key[(p-LANES)*KEY_W +: KEY_W];
            ix = (p < LANES) ? lo_idx[p*IDX_W +: IDX_W] : hi_idx[(p-LANES)*IDX_W +: IDX_W];
            checks++;
            if (ix < IBASE || ix >= IBASE + 2*LANES) begin
                fail("R5", $sformatf("index range pos %0d", p), ix, IBASE);
            end else if (seen[ix-IBASE]) begin
                fail("R5", $sformatf("duplicate index pos %0d", p), ix, 0);
            end else begin
                seen[ix-IBASE] = 1;
                if (orig_key[ix-IBASE] != k)
                    fail("R5", $sformatf("key/index pairing pos %0d", p), k, orig_key[ix-IBASE]);
            end
            if (tie_mode) begin
                checks++;
                if (ix != IBASE + p) fail("R6", $sformatf("tie lane pos %0d", p), ix, IBASE + p);
            end
        end
    endtask

    // One cycle: wait for the falling edge, then compare timing against the model
    task automatic tick();
        @(negedge clk);
        checks++;
        if (busy !== mbusy) fail("R3", "busy", busy, mbusy);
        if (done !== mdone) fail("R3", "done", done, mdone);
        if (mdone) check_result();
    endtask

    task automatic drive(input vec_t ka, input vec_t kb);
        for (int l = 0; l < LANES; l++) begin
            a_key[l*KEY_W +: KEY_W] = ka[l];
            b_key[l*KEY_W +: KEY_W] = kb[l];
            a_idx[l*IDX_W +: IDX_W] = IBASE + l;
            b_idx[l*IDX_W +: IDX_W] = IBASE + LANES + l;
        end
    endtask

    // Apply a start for one cycle; expectations are set only if the model accepts it
    task automatic launch(input vec_t ka, input vec_t kb, input bit ties);
        int unsigned q [$];
        drive(ka, kb);
        if (!mbusy) begin
            q = {};
            for (int l = 0; l < LANES; l++) begin
                orig_key[l] = ka[l];
                orig_key[LANES+l] = kb[l];
                q.push_back(ka[l]);
                q.push_back(kb[l]);
            end
            q.sort();
            foreach (q[j]) exp_sorted[j] = q[j];
            tie_mode = ties;
            result_seen = 0;
        end
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!mdone && guard < 4*LANES) begin
            tick();
            guard++;
        end
        checks++;
        if (!result_seen) fail("R3", "no done pulse", 0, 1);
    endtask

    task automatic sorted_vec(output vec_t v, inout int unsigned seed, input int unsigned mask);
        int unsigned q [$];
        q = {};
        for (int l = 0; l < LANES; l++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            q.push_back((seed >> 3) & mask);
        end
        q.sort();
        foreach (q[j]) v[j] = q[j];
    endtask

    initial begin
        vec_t va, vb;
        int unsigned seed;
        logic [LANES*KEY_W-1:0] hold_lo, hold_hi;
        logic [LANES*IDX_W-1:0] hold_li, hold_hi_i;

        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0) fail("R1", "busy/done in reset", {busy, done}, 0);
        checks++;
        if (lo_key !== '0 || hi_key !== '0 || lo_idx !== '0 || hi_idx !== '0)
            fail("R1", "outputs in reset", lo_key[31:0], 0);
        rst_n = 1'b1;
        tick();
        checks++;
        if (busy !== 1'b0 || lo_key !== '0) fail("R1", "after reset release", busy, 0);

        // R2, R4, R5: interleaved inputs
        for (int l = 0; l < LANES; l++) begin va[l] = 2*l + 1; vb[l] = 2*l + 2; end
        launch(va, vb, 0);
        checks++;
        if (busy !== 1'b1) fail("R2", "busy after start", busy, 1);
        wait_done();

        // R4: A entirely below B
        for (int l = 0; l < LANES; l++) begin va[l] = l; vb[l] = 100 + l; end
        launch(va, vb, 0);
        wait_done();

        // R4: A entirely above B, with extreme values
        for (int l = 0; l < LANES; l++) begin va[l] = 32'hFFFF_FFF0 + l; vb[l] = l; end
        va[LANES-1] = 32'hFFFF_FFFF;
        launch(va, vb, 0);
        wait_done();

        // R6: every key equal, nothing may move
        for (int l = 0; l < LANES; l++) begin va[l] = 7; vb[l] = 7; end
        launch(va, vb, 1);
        wait_done();

        // R5: many duplicates across both inputs
        for (int l = 0; l < LANES; l++) begin va[l] = l / 3; vb[l] = (l + 1) / 2; end
        launch(va, vb, 0);
        wait_done();

        // R4, R5: pseudo-random sorted inputs, some with narrow ranges
        seed = 32'h1234_5678;
        for (int t = 0; t < 12; t++) begin
            sorted_vec(va, seed, (t % 3 == 0) ? 32'h3 : 32'hFFFF_FFFF);
            sorted_vec(vb, seed, (t % 3 == 0) ? 32'h3 : 32'hFFFF_FFFF);
            launch(va, vb, 0);
            wait_done();
        end

        // R7: start while busy is ignored
        for (int l = 0; l < LANES; l++) begin va[l] = 10*l; vb[l] = 10*l + 5; end
        launch(va, vb, 0);
        tick(); tick();
        for (int l = 0; l < LANES; l++) begin va[l] = 1000 + l; vb[l] = 2000 + l; end
        checks++;
        if (!mbusy) fail("R7", "expected busy before extra start", 0, 1);
        launch(va, vb, 0);
        wait_done();

        // R8: outputs hold after done while inputs change
        hold_lo = lo_key; hold_hi = hi_key; hold_li = lo_idx; hold_hi_i = hi_idx;
        for (int c = 0; c < 5; c++) begin
            a_key = {LANES{32'hDEAD_0000 + c}};
            b_idx = '1;
            tick();
            checks++;
            if (lo_key !== hold_lo || hi_key !== hold_hi || lo_idx !== hold_li || hi_idx !== hold_hi_i)
                fail("R8", "output changed while idle", lo_key[31:0], hold_lo[31:0]);
        end

        // R9: start in the done cycle begins a new run
        for (int l = 0; l < LANES; l++) begin va[l] = 3*l; vb[l] = 3*l + 1; end
        launch(va, vb, 0);
        wait_done();
        checks++;
        if (done !== 1'b1) fail("R9", "done before back-to-back start", done, 1);
        for (int l = 0; l < LANES; l++) begin va[l] = 50 - l + 2*l; vb[l] = 40 + l; end
        launch(va, vb, 0);
        checks++;
        if (busy !== 1'b1) fail("R9", "busy after start on done cycle", busy, 1);
        wait_done();

        repeat (3) tick();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule